// File: doc/BRIEF.md
# Gapped T1 Receive Clock Generator

This block produces the receive serial clock for a fractional T1 receive path when the block is the clock master. It runs in the system clock domain. A 1.544 MHz bit enable marks each T1 bit period. The block tracks the 193 bit positions of the frame and emits a one-cycle registered clock-enable pulse for each position. It withholds that pulse at positions that software has chosen to remove. Those positions can be the framing bit, whole channels chosen by a 24-bit mask, or the eighth bit of every channel, which is the 56 kb/s option.

Along with the pulse, the block presents a data-valid level and the channel and bit indices of the current position. Downstream logic can capture payload only where it is meaningful and ignore the don't-care data under a gap. A frame-start pulse aligns the position counter to the framing bit. Without it, the counter wraps on its own after 193 positions.

Top module: `t1_gapped_rxclk`

## Requirements
- R1: `rclk_pulse` is high for exactly the one system clock cycle that follows an edge where `bit_en` was high and the new position is not gapped. It is low in every other cycle.
- R2: When `frame_start` and `bit_en` are high at the same edge, the new position is the framing bit (position 0), whatever the old position was. A `frame_start` that arrives without `bit_en` has no effect on the next position.
- R3: A frame has 193 positions, numbered 0 to 192. The position advances by one on each tick and wraps from 192 to 0. The first tick after reset lands on position 0.
- R4: Position 0 reports `chan_idx`=0 and `bit_idx`=0. Position p≥1 reports `chan_idx`=(p-1)/8+1 (1..24) and `bit_idx`=((p-1) mod 8)+1. Bit 1 is the MSB and is sent first.
- R5: When `fbit_gap_en`=1, position 0 is gapped: there is no pulse and `rdata_valid`=0.
- R6: Channel k (1..24) is gapped only when `chan_gap_mask[k-1]`=1 and `chan_gap_en`=1. With `chan_gap_en`=0 the mask has no effect.
- R7: When `bit8_gap_en`=1, bit 8 (`bit_idx`=8) of every channel is gapped.
- R8: `rdata_valid` equals "not gapped" for the current position. It and both indices change only on a tick and hold in between.
- R9: While `rst_n` is low, `rclk_pulse`, `rdata_valid`, `chan_idx` and `bit_idx` are all 0.
- R10: The gap controls are sampled only at a tick edge. Changing them between ticks does not alter the current `rdata_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_en | input | 1 | One-cycle tick per 1.544 MHz bit period |
| frame_start | input | 1 | Marks the tick that carries the framing bit |
| fbit_gap_en | input | 1 | Remove the framing-bit pulse |
| chan_gap_en | input | 1 | Enable channel gapping by mask |
| chan_gap_mask | input | 24 | Bit k-1 selects channel k for gapping |
| bit8_gap_en | input | 1 | Remove the eighth-bit pulse of each channel |
| rclk_pulse | output | 1 | Registered gapped clock enable, one cycle per kept bit |
| rdata_valid | output | 1 | Current position carries valid data |
| chan_idx | output | 5 | Current channel, 0 for the framing bit |
| bit_idx | output | 4 | Current bit in channel (1..8), 0 for the framing bit |

## Verification
The bench sweeps every channel with a single-bit mask and checks that exactly that channel's eight pulses disappear. A decoder that is off by one in mask indexing would gap the neighbouring channel and be caught. It runs past 192 without a frame start to catch a counter that misses the wrap or wraps at 191 or 193. It also re-syncs mid-frame and pulses `frame_start` between ticks to catch a counter that acts on an unqualified frame start. The remaining cases are these: the mask with channel gapping disabled, which would wrongly gap if the enable were ignored; the bit-8 and framing-bit options combined; and a configuration change between ticks, which a design that does not register its decision would show at once on `rdata_valid`.

// File: rtl/t1g_pkg.sv
package t1g_pkg;
  localparam int T1G_CHANNELS    = 24;
  localparam int T1G_BITS_PER_CH = 8;

  typedef struct packed {
    logic fbit;
    logic chan;
    logic bit8;
  } t1g_gap_ctl_t;
endpackage

// File: rtl/t1g_bit_counter.sv
module t1g_bit_counter #(
  parameter int FRAME_BITS = 193,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             frame_start,
  output logic [POS_W-1:0] pos_n,
  output logic [POS_W-1:0] pos_q
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  always_comb begin
    pos_n = pos_q;
    if (bit_en) begin
      if (frame_start)        pos_n = '0;
      else if (pos_q == LAST) pos_n = '0;
      else                    pos_n = pos_q + POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= LAST;
    else        pos_q <= pos_n;
  end

  AST_SYNC_TO_FBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && frame_start) |=> (pos_q == '0)); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en) |=> $stable(pos_q)); // R2
  AST_WRAP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !frame_start && pos_q == LAST) |=> (pos_q == '0)); // R3
endmodule

// File: rtl/t1g_pos_decode.sv
module t1g_pos_decode #(
  parameter int CHANNELS    = 24,
  parameter int BITS_PER_CH = 8,
  localparam int FRAME_BITS = 1 + CHANNELS * BITS_PER_CH,
  localparam int POS_W      = $clog2(FRAME_BITS),
  localparam int CH_W       = $clog2(CHANNELS + 1),
  localparam int BIT_W      = $clog2(BITS_PER_CH + 1)
) (
  input  logic [POS_W-1:0] pos,
  output logic [CH_W-1:0]  chan,
  output logic [BIT_W-1:0] bitn
);
  logic [POS_W-1:0] slot;
  logic             is_fbit;

  assign is_fbit = (pos == '0);
  assign slot    = pos - POS_W'(1);

  always_comb begin
    if (is_fbit) begin
      chan = '0;
      bitn = '0;
    end else begin
      chan = CH_W'(slot / POS_W'(BITS_PER_CH)) + CH_W'(1);
      bitn = BIT_W'(slot % POS_W'(BITS_PER_CH)) + BIT_W'(1);
    end
  end
endmodule

// File: rtl/t1g_gap_select.sv
module t1g_gap_select
  import t1g_pkg::*;
#(
  parameter int CHANNELS    = 24,
  parameter int BITS_PER_CH = 8,
  localparam int CH_W       = $clog2(CHANNELS + 1),
  localparam int BIT_W      = $clog2(BITS_PER_CH + 1)
) (
  input  t1g_gap_ctl_t         ctl,
  input  logic [CHANNELS-1:0]  mask,
  input  logic [CH_W-1:0]      chan,
  input  logic [BIT_W-1:0]     bitn,
  output logic                 gap
);
  logic [CHANNELS-1:0] hit;
  logic                mask_hit;
  logic                on_fbit;
  logic                on_last_bit;

  for (genvar k = 0; k < CHANNELS; k++) begin : g_chan
    assign hit[k] = mask[k] && (chan == CH_W'(k + 1));
  end

  assign mask_hit    = |hit;
  assign on_fbit     = (chan == '0);
  assign on_last_bit = (bitn == BIT_W'(BITS_PER_CH));

  always_comb begin
    if (on_fbit) gap = ctl.fbit;
    else         gap = (ctl.chan && mask_hit) || (ctl.bit8 && on_last_bit);
  end
endmodule

// File: rtl/t1_gapped_rxclk.sv
module t1_gapped_rxclk
  import t1g_pkg::*;
#(
  parameter int CHANNELS    = T1G_CHANNELS,
  parameter int BITS_PER_CH = T1G_BITS_PER_CH,
  localparam int FRAME_BITS = 1 + CHANNELS * BITS_PER_CH,
  localparam int POS_W      = $clog2(FRAME_BITS),
  localparam int CH_W       = $clog2(CHANNELS + 1),
  localparam int BIT_W      = $clog2(BITS_PER_CH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic                frame_start,
  input  logic                fbit_gap_en,
  input  logic                chan_gap_en,
  input  logic [CHANNELS-1:0] chan_gap_mask,
  input  logic                bit8_gap_en,
  output logic                rclk_pulse,
  output logic                rdata_valid,
  output logic [CH_W-1:0]     chan_idx,
  output logic [BIT_W-1:0]    bit_idx
);
  logic [POS_W-1:0] pos_n;
  logic [POS_W-1:0] pos_q;
  logic [CH_W-1:0]  chan_n;
  logic [BIT_W-1:0] bit_n;
  logic             gap_n;
  t1g_gap_ctl_t     ctl;

  logic             pulse_d, valid_d;
  logic [CH_W-1:0]  chan_d;
  logic [BIT_W-1:0] bit_d;

  assign ctl.fbit = fbit_gap_en;
  assign ctl.chan = chan_gap_en;
  assign ctl.bit8 = bit8_gap_en;

  t1g_bit_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .pos_n(pos_n), .pos_q(pos_q)
  );

  t1g_pos_decode #(.CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH)) u_dec (
    .pos(pos_n), .chan(chan_n), .bitn(bit_n)
  );

  t1g_gap_select #(.CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH)) u_gap (
    .ctl(ctl), .mask(chan_gap_mask), .chan(chan_n), .bitn(bit_n), .gap(gap_n)
  );

  always_comb begin
    pulse_d = bit_en && !gap_n;
    valid_d = rdata_valid;
    chan_d  = chan_idx;
    bit_d   = bit_idx;
    if (bit_en) begin
      valid_d = !gap_n;
      chan_d  = chan_n;
      bit_d   = bit_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rclk_pulse  <= 1'b0;
      rdata_valid <= 1'b0;
      chan_idx    <= '0;
      bit_idx     <= '0;
    end else begin
      rclk_pulse  <= pulse_d;
      rdata_valid <= valid_d;
      chan_idx    <= chan_d;
      bit_idx     <= bit_d;
    end
  end

  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    rclk_pulse |-> ($past(bit_en) && rdata_valid)); // R1
  AST_FBIT_REMOVED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_en) && rdata_valid && chan_idx == '0) |-> !$past(fbit_gap_en)); // R5
  AST_BIT8_REMOVED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_en) && rdata_valid && bit_idx == BIT_W'(BITS_PER_CH)) |-> !$past(bit8_gap_en)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en) |=> (!rclk_pulse && $stable(rdata_valid) && $stable(chan_idx) && $stable(bit_idx))); // R8
endmodule

// File: tb/t1_gapped_rxclk_test.sv
`timescale 1ns/1ps
module t1_gapped_rxclk_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en, frame_start, fbit_gap_en, chan_gap_en, bit8_gap_en;
  logic [23:0] chan_gap_mask;
  logic        rclk_pulse, rdata_valid;
  logic [4:0]  chan_idx;
  logic [3:0]  bit_idx;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_pos = 192;
  bit finished = 0;

  always #2.5 clk = ~clk;

  t1_gapped_rxclk uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .fbit_gap_en(fbit_gap_en), .chan_gap_en(chan_gap_en),
    .chan_gap_mask(chan_gap_mask), .bit8_gap_en(bit8_gap_en),
    .rclk_pulse(rclk_pulse), .rdata_valid(rdata_valid),
    .chan_idx(chan_idx), .bit_idx(bit_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (pos %0d)", tag, act, exp, exp_pos);
    end
  endtask

  function automatic int exp_chan(input int p);
    return (p == 0) ? 0 : (p - 1) / 8 + 1;
  endfunction
  function automatic int exp_bit(input int p);
    return (p == 0) ? 0 : (p - 1) % 8 + 1;
  endfunction
  function automatic bit exp_gap(input int p);
    int c;
    c = exp_chan(p);
    if (c == 0) return fbit_gap_en;
    return (chan_gap_en && chan_gap_mask[c-1]) || (bit8_gap_en && exp_bit(p) == 8);
  endfunction

  // One bit period: tick, check registered outputs, then an idle cycle check.
  task automatic tick(input bit fs);
    bit g;
    @(negedge clk);
    bit_en = 1'b1;
    frame_start = fs;
    exp_pos = fs ? 0 : ((exp_pos == 192) ? 0 : exp_pos + 1);
    g = exp_gap(exp_pos);
    @(negedge clk);
    bit_en = 1'b0;
    frame_start = 1'b0;
    chk("R1 pulse", rclk_pulse, !g);
    chk("R8 valid", rdata_valid, !g);
    chk("R4 chan", chan_idx, exp_chan(exp_pos));
    chk("R4 bit", bit_idx, exp_bit(exp_pos));
    @(negedge clk);
    chk("R1 pulse width", rclk_pulse, 0);
    chk("R8 hold valid", rdata_valid, !g);
    chk("R8 hold chan", chan_idx, exp_chan(exp_pos));
  endtask

  task automatic run_frame();
    tick(1'b1);
    repeat (192) tick(1'b0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bit_en = 1'b0; frame_start = 1'b0;
    fbit_gap_en = 1'b0; chan_gap_en = 1'b0; bit8_gap_en = 1'b0;
    chan_gap_mask = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset pulse", rclk_pulse, 0);
    chk("R9 reset valid", rdata_valid, 0);
    chk("R9 reset chan", chan_idx, 0);
    chk("R9 reset bit", bit_idx, 0);
    rst_n = 1'b1;

    // R3: first tick after reset lands on position 0, then a full frame and wrap
    tick(1'b0);
    chk("R3 first tick pos0", chan_idx, 0);
    repeat (192) tick(1'b0);
    chk("R3 reached 192 chan", chan_idx, 24);
    chk("R3 reached 192 bit", bit_idx, 8);
    tick(1'b0);
    chk("R3 wrap to fbit", chan_idx, 0);
    repeat (4) tick(1'b0);

    // R2: resync mid-frame, then frame_start without a tick is ignored
    repeat (50) tick(1'b0);
    tick(1'b1);
    chk("R2 resync chan", chan_idx, 0);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    tick(1'b0);
    chk("R2 stray frame_start ignored", bit_idx, 1);

    // R10: config change between ticks leaves the current decision alone
    tick(1'b1);
    fbit_gap_en = 1'b1;
    @(negedge clk);
    chk("R10 valid unchanged", rdata_valid, 1);
    chk("R10 no pulse", rclk_pulse, 0);

    // R5: framing-bit gap
    run_frame();
    fbit_gap_en = 1'b0;

    // R6: mask ignored without enable, then applied
    chan_gap_mask = 24'hA50F31;
    run_frame();
    chan_gap_en = 1'b1;
    run_frame();

    // R6: sweep one channel at a time
    for (int k = 0; k < 24; k++) begin
      chan_gap_mask = 24'h1 << k;
      run_frame();
    end

    // R7 with R5 and R6 combined
    chan_gap_mask = 24'h800001;
    bit8_gap_en = 1'b1;
    fbit_gap_en = 1'b1;
    run_frame();
    chan_gap_en = 1'b0;
    fbit_gap_en = 1'b0;
    run_frame();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule